// File: doc/BRIEF.md
# I/O Page Register Decoder

This block hangs off a small processor-style bus that carries separate qualifiers and strobes for memory and I/O cycles. An access counts as an I/O access only when the I/O-select qualifier is high and the memory-select qualifier is low. It must also fall in the I/O page, which is the set of addresses whose upper byte is all ones. Inside that page, the low address byte picks an 8-bit register. Writes land on the rising clock edge. Reads come back combinationally on a read data bus while the I/O read strobe is high.

In the normal decode mode the page holds four kinds of register:
- four full-width write-only control registers;
- two narrow 4-bit registers that can be read back;
- eight 1-bit flag registers, each at its own address, so software can flip one flag without a read-modify-write.

A mode input switches to a reduced decode. In that mode each low address bit acts directly as the chip select of one of eight write-only registers.

Top module: `io_page_regs`

## Requirements
- R1: A register changes only on a rising clock edge where io_sel_i is 1, mem_sel_i is 0 and io_wr_i is 1; with mem_sel_i high, io_sel_i low or io_wr_i low, no output register changes.
- R2: Only addresses with addr_i[15:8] equal to 0xFF reach any register; any other upper byte leaves every register unchanged and reads 0x00.
- R3: In normal mode (onehot_mode_i = 0), low address 0x00+k (k = 0..3) writes wdata_i into write-only register k, seen on wo_regs_o[8k+7:8k] after the edge.
- R4: In normal mode, low address 0x10+k (k = 0..1) stores wdata_i[3:0] into narrow register k (rd_regs_o[4k+3:4k]); a qualified read of that address returns {4'b0000, value} on rdata_o.
- R5: rdata_o is 0x00 when io_rd_i is low, when the access is not a qualified I/O page access, when the address is not a readable register, or in one-hot mode.
- R6: In normal mode, low address 0x20+k (k = 0..7) stores wdata_i[0] into flag k (flags_o[k]); the other flags keep their values.
- R7: In one-hot mode, every set bit k of addr_i[7:0] writes wdata_i into one-hot register k (oh_regs_o[8k+7:8k]), so several registers can take the same data in one cycle, and the normal-mode registers do not change.
- R8: In normal mode the one-hot registers never change.
- R9: An active-low reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data |
| io_sel_i | input | 1 | I/O space qualifier |
| mem_sel_i | input | 1 | Memory space qualifier |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| onehot_mode_i | input | 1 | 1 selects the one-hot chip-select decode |
| wo_regs_o | output | 32 | Write-only control registers, packed |
| rd_regs_o | output | 8 | Narrow readable registers, packed |
| flags_o | output | 8 | Single-bit flag registers |
| oh_regs_o | output | 64 | One-hot mode registers, packed |
| rdata_o | output | 8 | Read data |

## Verification
A read and a write can occur in the same cycle, because both strobes may be high together, and they may even target the same readable register. The random stimulus raises the two strobes together often. It also aims a fair share of accesses at the readable addresses, so these collisions happen many times. The bench judges each collision by two rules: the read value in that cycle must equal the register contents before the edge, and the new data must show on the register outputs only after the edge.

// File: rtl/io_page_pkg.sv
package io_page_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PAGE_W   = ADDR_W - DATA_W;
  localparam int unsigned N_WO     = 4;
  localparam int unsigned N_RD     = 2;
  localparam int unsigned RD_W     = 4;
  localparam int unsigned N_FLAG   = 8;
  localparam int unsigned N_OH     = DATA_W;
  localparam logic [DATA_W-1:0] WO_BASE   = 8'h00;
  localparam logic [DATA_W-1:0] RD_BASE   = 8'h10;
  localparam logic [DATA_W-1:0] FLAG_BASE = 8'h20;

  typedef struct packed {
    logic [N_WO-1:0]   wo;
    logic [N_RD-1:0]   rd;
    logic [N_FLAG-1:0] flag;
    logic [N_OH-1:0]   oh;
  } wr_en_t;
endpackage

// File: rtl/io_page_detect.sv
module io_page_detect
  import io_page_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  output logic              page_hit_o
);
  logic page_n;
  assign page_n     = ~&page_i;  // wide NAND, active-low page select
  assign page_hit_o = ~page_n;
endmodule

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_page_pkg::*;
(
  input  logic [DATA_W-1:0] low_i,
  input  logic              wr_go_i,
  input  logic              onehot_i,
  output wr_en_t            we_o,
  output logic [N_RD-1:0]   rd_hit_o
);
  logic norm_wr;
  logic oh_wr;
  assign norm_wr = wr_go_i & ~onehot_i;
  assign oh_wr   = wr_go_i & onehot_i;

  for (genvar k = 0; k < N_WO; k++) begin : g_wo
    assign we_o.wo[k] = norm_wr & (low_i == WO_BASE + DATA_W'(k));
  end
  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    assign rd_hit_o[k] = ~onehot_i & (low_i == RD_BASE + DATA_W'(k));
    assign we_o.rd[k]  = norm_wr & (low_i == RD_BASE + DATA_W'(k));
  end
  for (genvar k = 0; k < N_FLAG; k++) begin : g_flag
    assign we_o.flag[k] = norm_wr & (low_i == FLAG_BASE + DATA_W'(k));
  end
  for (genvar k = 0; k < N_OH; k++) begin : g_oh
    assign we_o.oh[k] = oh_wr & low_i[k];
  end
endmodule

// File: rtl/io_reg_bank.sv
module io_reg_bank
  import io_page_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  wr_en_t                 we_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [N_WO*DATA_W-1:0] wo_o,
  output logic [N_RD*RD_W-1:0]   rd_o,
  output logic [N_FLAG-1:0]      flag_o,
  output logic [N_OH*DATA_W-1:0] oh_o
);
  for (genvar k = 0; k < N_WO; k++) begin : g_wo
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          wo_o[k*DATA_W +: DATA_W] <= '0;
      else if (we_i.wo[k])  wo_o[k*DATA_W +: DATA_W] <= wdata_i;
    end
  end
  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          rd_o[k*RD_W +: RD_W] <= '0;
      else if (we_i.rd[k])  rd_o[k*RD_W +: RD_W] <= wdata_i[RD_W-1:0];
    end
  end
  for (genvar k = 0; k < N_FLAG; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_o[k] <= 1'b0;
      else if (we_i.flag[k])  flag_o[k] <= wdata_i[0];
    end
  end
  for (genvar k = 0; k < N_OH; k++) begin : g_oh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          oh_o[k*DATA_W +: DATA_W] <= '0;
      else if (we_i.oh[k])  oh_o[k*DATA_W +: DATA_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
  import io_page_pkg::*;
(
  input  logic                 rd_go_i,
  input  logic [N_RD-1:0]      rd_hit_i,
  input  logic [N_RD*RD_W-1:0] rd_regs_i,
  output logic [DATA_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_go_i) begin
      for (int k = 0; k < N_RD; k++) begin
        if (rd_hit_i[k]) rdata_o = DATA_W'(rd_regs_i[k*RD_W +: RD_W]);
      end
    end
  end
endmodule

// File: rtl/io_page_regs.sv
module io_page_regs
  import io_page_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   io_sel_i,
  input  logic                   mem_sel_i,
  input  logic                   io_rd_i,
  input  logic                   io_wr_i,
  input  logic                   onehot_mode_i,
  output logic [N_WO*DATA_W-1:0] wo_regs_o,
  output logic [N_RD*RD_W-1:0]   rd_regs_o,
  output logic [N_FLAG-1:0]      flags_o,
  output logic [N_OH*DATA_W-1:0] oh_regs_o,
  output logic [DATA_W-1:0]      rdata_o
);
  logic            page_hit;
  logic            io_acc;
  logic            wr_go;
  logic            rd_go;
  wr_en_t          we;
  logic [N_RD-1:0] rd_hit;

  io_page_detect u_page (
    .page_i     (addr_i[ADDR_W-1:DATA_W]),
    .page_hit_o (page_hit)
  );

  assign io_acc = io_sel_i & ~mem_sel_i & page_hit;
  assign wr_go  = io_acc & io_wr_i;
  assign rd_go  = io_acc & io_rd_i;

  io_addr_decode u_dec (
    .low_i    (addr_i[DATA_W-1:0]),
    .wr_go_i  (wr_go),
    .onehot_i (onehot_mode_i),
    .we_o     (we),
    .rd_hit_o (rd_hit)
  );

  io_reg_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (wdata_i),
    .wo_o    (wo_regs_o),
    .rd_o    (rd_regs_o),
    .flag_o  (flags_o),
    .oh_o    (oh_regs_o)
  );

  io_read_mux u_rmux (
    .rd_go_i   (rd_go),
    .rd_hit_i  (rd_hit),
    .rd_regs_i (rd_regs_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/io_page_regs_chk.sv
module io_page_regs_chk
  import io_page_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   io_sel_i,
  input logic                   mem_sel_i,
  input logic                   io_rd_i,
  input logic                   io_wr_i,
  input logic                   onehot_mode_i,
  input logic [N_WO*DATA_W-1:0] wo_regs_o,
  input logic [N_RD*RD_W-1:0]   rd_regs_o,
  input logic [N_FLAG-1:0]      flags_o,
  input logic [N_OH*DATA_W-1:0] oh_regs_o,
  input logic [DATA_W-1:0]      rdata_o
);
  logic [N_WO*DATA_W+N_RD*RD_W+N_FLAG+N_OH*DATA_W-1:0] all_q;
  assign all_q = {wo_regs_o, rd_regs_o, flags_o, oh_regs_o};

  a_r1_unqualified_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sel_i || !io_sel_i || !io_wr_i) |=> $stable(all_q));

  a_r2_off_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:DATA_W] != '1) |=> $stable(all_q));

  a_r2_off_page_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:DATA_W] != '1) |-> (rdata_o == '0));

  a_r4_narrow_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:RD_W] == '0);

  a_r5_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || onehot_mode_i) |-> (rdata_o == '0));

  a_r7_normal_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    onehot_mode_i |=> ($stable(wo_regs_o) && $stable(rd_regs_o) && $stable(flags_o)));

  a_r8_onehot_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !onehot_mode_i |=> $stable(oh_regs_o));
endmodule

bind io_page_regs io_page_regs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .io_sel_i      (io_sel_i),
  .mem_sel_i     (mem_sel_i),
  .io_rd_i       (io_rd_i),
  .io_wr_i       (io_wr_i),
  .onehot_mode_i (onehot_mode_i),
  .wo_regs_o     (wo_regs_o),
  .rd_regs_o     (rd_regs_o),
  .flags_o       (flags_o),
  .oh_regs_o     (oh_regs_o),
  .rdata_o       (rdata_o)
);

// File: tb/io_page_regs_tb.sv
module io_page_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        io_sel = 1'b0, mem_sel = 1'b0, io_rd = 1'b0, io_wr = 1'b0, ohm = 1'b0;
  logic [31:0] wo_q;
  logic [7:0]  rd_q;
  logic [7:0]  fl_q;
  logic [63:0] oh_q;
  logic [7:0]  rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_wo [4];
  logic [3:0] m_rd [2];
  logic       m_fl [8];
  logic [7:0] m_oh [8];

  always #4 clk = ~clk;

  io_page_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .io_sel_i(io_sel), .mem_sel_i(mem_sel), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .onehot_mode_i(ohm), .wo_regs_o(wo_q), .rd_regs_o(rd_q), .flags_o(fl_q),
    .oh_regs_o(oh_q), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit qual();
    return io_sel && !mem_sel && addr[15:8] == 8'hFF;
  endfunction

  function automatic logic [7:0] exp_read();
    if (io_rd && qual() && !ohm && (addr[7:0] == 8'h10 || addr[7:0] == 8'h11))
      return {4'b0, m_rd[addr[0]]};
    return 8'h00;
  endfunction

  task automatic model_write();
    if (!(io_wr && qual())) return;
    if (ohm) begin
      for (int k = 0; k < 8; k++) if (addr[k]) m_oh[k] = wdata;
    end else begin
      if (addr[7:0] < 8'h04) m_wo[addr[1:0]] = wdata;
      else if (addr[7:0] == 8'h10 || addr[7:0] == 8'h11) m_rd[addr[0]] = wdata[3:0];
      else if (addr[7:3] == 5'b00100) m_fl[addr[2:0]] = wdata[0];
    end
  endtask

  task automatic cmp_all(input string tag);
    for (int k = 0; k < 4; k++) chk({tag, " R3 wo"}, 64'(wo_q[8*k +: 8]), 64'(m_wo[k]));
    for (int k = 0; k < 2; k++) chk({tag, " R4 rd"}, 64'(rd_q[4*k +: 4]), 64'(m_rd[k]));
    for (int k = 0; k < 8; k++) chk({tag, " R6 flag"}, 64'(fl_q[k]), 64'(m_fl[k]));
    for (int k = 0; k < 8; k++) chk({tag, " R7/R8 oh"}, 64'(oh_q[8*k +: 8]), 64'(m_oh[k]));
  endtask

  // drive at negedge, check read before edge, step one cycle, check registers
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic s, input logic m,
                     input logic r, input logic w, input logic o, input string tag);
    addr = a; wdata = d; io_sel = s; mem_sel = m; io_rd = r; io_wr = w; ohm = o;
    #1;
    chk({tag, " R5/R4 rdata"}, 64'(rdata), 64'(exp_read()));
    model_write();
    @(negedge clk);
    cmp_all(tag);
  endtask

  function automatic logic [15:0] rnd_addr();
    logic [7:0] hi, lo;
    int p;
    hi = ($urandom % 8 == 0) ? 8'($urandom) : 8'hFF;
    p = $urandom % 5;
    case (p)
      0: lo = 8'($urandom % 4);
      1: lo = 8'h10 + 8'($urandom % 2);
      2: lo = 8'h20 + 8'($urandom % 8);
      default: lo = 8'($urandom);
    endcase
    return {hi, lo};
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) m_wo[k] = '0;
    for (int k = 0; k < 2; k++) m_rd[k] = '0;
    for (int k = 0; k < 8; k++) begin m_fl[k] = 1'b0; m_oh[k] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    cmp_all("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    cyc(16'hFF02, 8'hA5, 1, 0, 0, 1, 0, "R3 write");
    cyc(16'hFF02, 8'h3C, 1, 1, 0, 1, 0, "R1 mem_sel");
    cyc(16'hFF02, 8'h3C, 0, 0, 0, 1, 0, "R1 no io_sel");
    cyc(16'hFE02, 8'h3C, 1, 0, 1, 1, 0, "R2 off page");
    cyc(16'hFF11, 8'hF9, 1, 0, 0, 1, 0, "R4 write");
    cyc(16'hFF11, 8'h06, 1, 0, 1, 1, 0, "R4 same-cycle rw");
    cyc(16'hFF11, 8'h00, 1, 0, 1, 0, 0, "R4 readback");
    chk("R4 readback value", 64'(rdata), 64'h06);
    cyc(16'hFF02, 8'h00, 1, 0, 1, 0, 0, "R5 write-only read");
    cyc(16'hFF23, 8'hFF, 1, 0, 0, 1, 0, "R6 flag set");
    cyc(16'hFF26, 8'h01, 1, 0, 0, 1, 0, "R6 flag set2");
    cyc(16'hFF23, 8'hFE, 1, 0, 0, 1, 0, "R6 flag clear");
    cyc(16'hFF81, 8'h77, 1, 0, 0, 1, 1, "R7 multi select");
    cyc(16'hFF11, 8'h0F, 1, 0, 1, 1, 1, "R7 onehot read");
    cyc(16'hFF00, 8'h55, 1, 0, 0, 1, 1, "R7 no bits");
    cyc(16'hFF01, 8'h99, 1, 0, 0, 1, 0, "R8 normal");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic s, m, r, w, o;
      s = ($urandom % 8) != 0;
      m = ($urandom % 8) == 0;
      r = $urandom % 2;
      w = ($urandom % 4) != 0;
      o = ($urandom % 6) == 0;
      cyc(rnd_addr(), 8'($urandom), s, m, r, w, o, "rand");
    end

    // reset mid-run
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < 4; k++) m_wo[k] = '0;
    for (int k = 0; k < 2; k++) m_rd[k] = '0;
    for (int k = 0; k < 8; k++) begin m_fl[k] = 1'b0; m_oh[k] = '0; end
    cmp_all("R9 async reset");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule